// File: doc/BRIEF.md
# Multi-Way Tag ECC Checker with Error Log

This block sits between a set-associative tag array and the tag compare logic of a cache. Every probe presents all eight ways stored at one cache index. Each stored way is a 25-bit codeword: 19 data bits plus 6 check bits that form a single-error-correct, double-error-detect code. The data bits are a valid bit, a dirty bit, a lock bit and a 16-bit tag. The block corrects single-bit faults combinationally, so the compare logic always receives clean tag words in the probe cycle. It flags words it cannot repair and reports whether the hit way holds a usable valid entry.

Faults are recorded in a small error log that software reads. The log has sticky single-error and double-error flags, the cache index of the failing probe, a way number and a syndrome. The syndrome is recorded for the hit way only, so a zero syndrome tells software that the fault was in some other way at the logged index. A double-bit event replaces an earlier single-bit record, but a pending double-bit record is never displaced. Each flag has its own interrupt enable. A global enable turns the whole mechanism off, and the stored words then pass through untouched.

Top module: `tag_ecc_guard`

## Requirements
- R1: Code layout, per way: bits 18:0 are data (bit 18 valid, 17 dirty, 16 lock, 15:0 tag). Data bit j sits at the j-th position, counting from 3 upward, that is not a power of two (3, 5, 6, 7, 9, ...). Check bit k (k = 0..4), held in code bit 19+k, is the XOR of the data bits whose position has bit k set. Code bit 24 makes the whole 25-bit word even parity. A clean word reaches `tag_out` unchanged and raises no flag.
- R2: With checking on, a single flipped bit anywhere in the 25 bits of any way is corrected on `tag_out` in the same cycle. It sets `sec_flag` at the clock edge that ends the probe.
- R3: With checking on, two flipped bits in a way set `ded_flag` and leave that way's data uncorrected on `tag_out`. They set `sec_flag` only if some other way has a single-bit fault.
- R4: `hit_valid` equals the corrected valid bit (bit 18) of the way selected by `hit_way`. It is forced low when that way has a double-bit error.
- R5: The logged syndrome is {parity mismatch, 5-bit recomputed-XOR-stored check mismatch} of the hit way when the hit way has an error of the class being logged, and zero otherwise. `log_way` is the hit way in the first case. Otherwise it is the lowest-numbered way with an error of that class, which is double-bit if any way has one and single-bit otherwise.
- R6: A logged probe records its `probe_idx` in `log_idx`.
- R7: A double-bit event overwrites the log unless `ded_flag` is already set. A single-bit-only event writes the log only when both flags are clear.
- R8: Both flags are sticky. `sec_clr` or `ded_clr`, held high for one cycle, clears its flag. A new event in the same cycle wins over the clear.
- R9: `irq` is high while (`sec_flag` and `sec_ie`) or (`ded_flag` and `ded_ie`).
- R10: With `ecc_en` low, `tag_out` carries the raw data bits, the check bits are ignored, and neither flags nor log change.
- R11: Without `probe`, corrupted codewords change neither the flags nor the log.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en | input | 1 | Enables checking, correction and logging |
| sec_ie | input | 1 | Interrupt enable for single-bit flag |
| ded_ie | input | 1 | Interrupt enable for double-bit flag |
| sec_clr | input | 1 | Clears single-bit flag |
| ded_clr | input | 1 | Clears double-bit flag |
| probe | input | 1 | Tag probe strobe |
| probe_idx | input | 11 | Cache index of the probe |
| hit_way | input | 3 | Way number that hit |
| code_in | input | 200 | Eight 25-bit stored codewords, way 0 in the low bits |
| tag_out | output | 152 | Eight corrected 19-bit tag words |
| hit_valid | output | 1 | Hit way holds a usable valid entry |
| sec_flag | output | 1 | Sticky single-bit error flag |
| ded_flag | output | 1 | Sticky double-bit error flag |
| log_idx | output | 11 | Logged failing index |
| log_way | output | 3 | Logged failing way |
| log_syn | output | 6 | Logged hit-way syndrome |
| irq | output | 1 | Interrupt |

## Verification
The bench flips every one of the 25 bits in every way and every bit pair in one way. Because of this, a wrong check-bit mapping, a mis-steered correction or a missed parity bit shows up as a wrong tag word or a wrong syndrome at a specific position. The hit way is rotated so that both the real-syndrome and the zero-syndrome cases of the log are hit. A design that logged a non-hit way's syndrome, or that picked the highest failing way, would give a wrong `log_syn` or `log_way`. Directed sequences cover several cases: a double-bit event replacing a single-bit record, later events leaving a pending double-bit record alone, a clear arriving in the same cycle as a new event, and the disabled and unprobed paths. A design with the wrong priority, or one that let the clear win, would leave the wrong index or a dropped flag.

// File: rtl/tag_ecc_guard.sv
`timescale 1ns/1ps
module tag_ecc_guard #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 19,
  parameter int IDX_W = 11,
  parameter int CHK_W = 6
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ecc_en,
  input  logic                   sec_ie,
  input  logic                   ded_ie,
  input  logic                   sec_clr,
  input  logic                   ded_clr,
  input  logic                   probe,
  input  logic [IDX_W-1:0]       probe_idx,
  input  logic [$clog2(WAYS)-1:0] hit_way,
  input  logic [WAYS*(TAG_W+CHK_W)-1:0] code_in,
  output logic [WAYS*TAG_W-1:0]  tag_out,
  output logic                   hit_valid,
  output logic                   sec_flag,
  output logic                   ded_flag,
  output logic [IDX_W-1:0]       log_idx,
  output logic [$clog2(WAYS)-1:0] log_way,
  output logic [CHK_W-1:0]       log_syn,
  output logic                   irq
);
  localparam int CW   = TAG_W + CHK_W;
  localparam int HB   = CHK_W - 1;
  localparam int NPOS = TAG_W + HB;
  localparam int WW   = $clog2(WAYS);

  // position of data bit j inside the Hamming numbering
  function automatic int hpos(input int j);
    int n;
    hpos = 0;
    n = 0;
    for (int p = 3; p < 256; p++)
      if ((p & (p - 1)) != 0) begin
        if (n == j && hpos == 0) hpos = p;
        n++;
      end
  endfunction

  function automatic logic [HB-1:0] hbits(input logic [TAG_W-1:0] d);
    int p;
    hbits = '0;
    for (int j = 0; j < TAG_W; j++) begin
      p = hpos(j);
      for (int k = 0; k < HB; k++)
        if (((p >> k) & 1) != 0) hbits[k] = hbits[k] ^ d[j];
    end
  endfunction

  logic [WAYS-1:0]             sec_w, ded_w, vld_w;
  logic [WAYS-1:0][CHK_W-1:0]  syn_w;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] raw, fix;
    logic [HB-1:0]    mis;
    logic             odd;

    assign raw = code_in[w*CW +: TAG_W];
    assign mis = hbits(raw) ^ code_in[w*CW+TAG_W +: HB];
    assign odd = ^code_in[w*CW +: CW];
    assign sec_w[w] = ecc_en & odd & (int'(mis) <= NPOS);
    assign ded_w[w] = ecc_en & ~sec_w[w] & (odd | (mis != '0));
    assign syn_w[w] = {odd, mis};

    for (genvar j = 0; j < TAG_W; j++) begin : g_bit
      localparam logic [HB-1:0] PJ = HB'(hpos(j));
      assign fix[j] = raw[j] ^ (sec_w[w] && mis == PJ);
    end

    assign tag_out[w*TAG_W +: TAG_W] = fix;
    assign vld_w[w] = fix[TAG_W-1];

    a_r2_single_fix: assert property (@(posedge clk) disable iff (!rst_n)
      sec_w[w] |-> $countones(fix ^ raw) <= 1);
    a_r3_no_repair: assert property (@(posedge clk) disable iff (!rst_n)
      ded_w[w] |-> fix == raw);
  end

  logic [WAYS-1:0] cls;
  logic [WW-1:0]   low;
  logic            hit_bad, any_sec, any_ded, take;

  always_comb begin
    cls = any_ded ? ded_w : sec_w;
    low = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (cls[w]) low = WW'(w);
    hit_bad = cls[hit_way];
  end

  assign any_sec   = |sec_w;
  assign any_ded   = |ded_w;
  assign hit_valid = vld_w[hit_way] & ~ded_w[hit_way];
  assign take = probe & ((any_ded & ~ded_flag) |
                         (~any_ded & any_sec & ~sec_flag & ~ded_flag));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_flag <= 1'b0;
      ded_flag <= 1'b0;
      log_idx  <= '0;
      log_way  <= '0;
      log_syn  <= '0;
    end else begin
      sec_flag <= (sec_flag & ~sec_clr) | (probe & any_sec);
      ded_flag <= (ded_flag & ~ded_clr) | (probe & any_ded);
      if (take) begin
        log_idx <= probe_idx;
        log_way <= hit_bad ? hit_way : low;
        log_syn <= hit_bad ? syn_w[hit_way] : '0;
      end
    end
  end

  assign irq = (sec_flag & sec_ie) | (ded_flag & ded_ie);

  a_r8_sec_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_flag && !sec_clr) |=> sec_flag);
  a_r7_ded_holds_log: assert property (@(posedge clk) disable iff (!rst_n)
    (ded_flag && !ded_clr) |=> ($stable(log_idx) && $stable(log_way) && $stable(log_syn)));
  a_r6_ded_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (probe && ecc_en && any_ded && !ded_flag) |=> (ded_flag && log_idx == $past(probe_idx)));
  a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ecc_en |=> $stable(log_idx));
  a_r11_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (!probe && !sec_clr && !ded_clr) |=> ($stable(sec_flag) && $stable(ded_flag)));
endmodule

// File: tb/tag_ecc_guard_tb_top.sv
`timescale 1ns/1ps
module tag_ecc_guard_tb_top;
  localparam int WAYS = 8, TW = 19, IW = 11, CK = 6, CW = 25;

  logic clk = 0, rst_n = 0;
  logic ecc_en = 1, sec_ie = 0, ded_ie = 0, sec_clr = 0, ded_clr = 0, probe = 0;
  logic [IW-1:0] probe_idx = '0;
  logic [2:0] hit_way = '0;
  logic [WAYS*CW-1:0] code_in = '0;
  logic [WAYS*TW-1:0] tag_out;
  logic hit_valid, sec_flag, ded_flag, irq;
  logic [IW-1:0] log_idx;
  logic [2:0] log_way;
  logic [CK-1:0] log_syn;

  tag_ecc_guard dut_i (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  logic [WAYS*CW-1:0] cw;
  logic [WAYS*TW-1:0] tg;

  task automatic chk(input string rq, input logic [199:0] act, input logic [199:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int bpos(input int j);
    int c, r;
    c = -1; r = 0;
    for (int p = 1; p < 64; p++)
      if ((p & (p - 1)) != 0 && p > 2) begin
        c++;
        if (c == j) r = p;
      end
    return r;
  endfunction

  function automatic logic [CW-1:0] enc(input logic [TW-1:0] d);
    int acc;
    logic [CW-1:0] c;
    acc = 0;
    for (int j = 0; j < TW; j++) if (d[j]) acc = acc ^ bpos(j);
    c = {1'b0, acc[4:0], d};
    c[24] = ^c[23:0];
    return c;
  endfunction

  function automatic logic [5:0] syn1(input int b);
    int t;
    if (b < 19) t = bpos(b);
    else if (b < 24) t = 1 << (b - 19);
    else t = 0;
    return {1'b1, t[4:0]};
  endfunction

  function automatic logic [TW-1:0] tag_of(input int w, input int idx, input bit v);
    int t;
    t = 32'hA000 + w * 273 + idx;
    return {v, 1'(w & 1), 1'b0, t[15:0]};
  endfunction

  task automatic setup(input int idx);
    for (int w = 0; w < WAYS; w++) begin
      tg[w*TW +: TW] = tag_of(w, idx, 1'b1);
      cw[w*CW +: CW] = enc(tg[w*TW +: TW]);
    end
  endtask

  task automatic clear_all();
    @(negedge clk); sec_clr = 1; ded_clr = 1;
    @(negedge clk); sec_clr = 0; ded_clr = 0;
  endtask

  task automatic drive(input int idx, input int hw);
    code_in = cw; probe_idx = IW'(idx); hit_way = 3'(hw); probe = 1;
    #2;
  endtask

  task automatic settle();
    @(negedge clk); probe = 0; sec_clr = 0; ded_clr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [WAYS*TW-1:0] etg;
    int idx, hw;
    repeat (3) @(negedge clk);
    sec_ie = 1; ded_ie = 1;
    #1;
    chk("R8 reset flags", {sec_flag, ded_flag, irq}, 3'b000);
    chk("R6 reset log", {log_idx, log_way, log_syn}, '0);
    rst_n = 1;
    sec_ie = 0; ded_ie = 0;
    @(negedge clk);

    // R1 clean words
    setup(5); drive(5, 0);
    chk("R1 clean tag_out", tag_out, tg);
    chk("R4 clean hit_valid", hit_valid, 1);
    settle();
    chk("R1 clean no flags", {sec_flag, ded_flag}, 2'b00);

    // R2/R5/R6 single-bit sweep over every way and bit
    for (int w = 0; w < WAYS; w++)
      for (int b = 0; b < CW; b++) begin
        clear_all();
        idx = (w * 25 + b * 7) % 2048;
        hw = (w + b) % 8;
        setup(idx);
        cw[w*CW + b] = ~cw[w*CW + b];
        drive(idx, hw);
        chk("R2 corrected tag_out", tag_out, tg);
        chk("R4 hit_valid after fix", hit_valid, 1);
        settle();
        chk("R2 sec flag only", {sec_flag, ded_flag}, 2'b10);
        chk("R6 log index", log_idx, idx);
        chk("R5 log syndrome", log_syn, (hw == w) ? syn1(b) : 6'd0);
        chk("R5 log way", log_way, w);
      end

    // R3 double-bit sweep over way 3
    for (int b1 = 0; b1 < CW; b1++)
      for (int b2 = b1 + 1; b2 < CW; b2++) begin
        clear_all();
        idx = (b1 * 31 + b2) % 2048;
        hw = ((b1 + b2) & 1) ? 3 : 6;
        setup(idx);
        cw[3*CW + b1] = ~cw[3*CW + b1];
        cw[3*CW + b2] = ~cw[3*CW + b2];
        etg = tg;
        etg[3*TW +: TW] = cw[3*CW +: TW];
        drive(idx, hw);
        chk("R3 uncorrected tag_out", tag_out, etg);
        chk("R4 hit_valid with ded", hit_valid, (hw == 3) ? 1'b0 : 1'b1);
        settle();
        chk("R3 ded flag only", {sec_flag, ded_flag}, 2'b01);
        chk("R5 ded syndrome", log_syn, (hw == 3) ? {1'b0, syn1(b1)[4:0] ^ syn1(b2)[4:0]} : 6'd0);
        chk("R5 ded way", log_way, 3);
      end

    // R7 ordering of log captures
    clear_all();
    setup(100); cw[2*CW + 4] ^= 1'b1; drive(100, 2); settle();
    chk("R7 first sec captured", log_idx, 100);
    setup(200); cw[5*CW + 1] ^= 1'b1; cw[5*CW + 2] ^= 1'b1; drive(200, 0); settle();
    chk("R7 ded overwrites sec idx", log_idx, 200);
    chk("R7 ded overwrites sec way", {log_way, log_syn}, {3'd5, 6'd0});
    chk("R7 both flags", {sec_flag, ded_flag}, 2'b11);
    setup(300); cw[1*CW + 0] ^= 1'b1; drive(300, 1); settle();
    chk("R7 sec keeps ded log", log_idx, 200);
    setup(400); cw[6*CW + 3] ^= 1'b1; cw[6*CW + 7] ^= 1'b1; drive(400, 6); settle();
    chk("R7 second ded keeps log", log_idx, 200);
    ded_clr = 1; @(negedge clk); ded_clr = 0;
    chk("R8 ded cleared alone", {sec_flag, ded_flag}, 2'b10);
    setup(500); cw[0*CW + 9] ^= 1'b1; drive(500, 0); settle();
    chk("R7 sec pending blocks sec", log_idx, 200);
    setup(600); cw[7*CW + 0] ^= 1'b1; cw[7*CW + 1] ^= 1'b1; drive(600, 7); settle();
    chk("R7 new ded after clear", {log_idx, log_way}, {11'd600, 3'd7});
    chk("R5 hit ded syndrome", log_syn, {1'b0, syn1(0)[4:0] ^ syn1(1)[4:0]});

    // R5 lowest failing way
    clear_all();
    setup(700); cw[6*CW] ^= 1'b1; cw[2*CW + 1] ^= 1'b1; drive(700, 7); settle();
    chk("R5 lowest sec way", {log_way, log_syn}, {3'd2, 6'd0});
    clear_all();
    setup(710); cw[6*CW] ^= 1'b1; cw[4*CW] ^= 1'b1; cw[4*CW + 1] ^= 1'b1; drive(710, 6);
    chk("R4 hit sec way valid", hit_valid, 1);
    settle();
    chk("R5 ded class beats hit sec", {log_way, log_syn}, {3'd4, 6'd0});
    chk("R3 both flags mixed", {sec_flag, ded_flag}, 2'b11);

    // R8 set wins over clear
    setup(720); cw[1*CW + 2] ^= 1'b1; sec_clr = 1; drive(720, 1); settle();
    chk("R8 set beats clear", sec_flag, 1);
    sec_clr = 1; @(negedge clk); sec_clr = 0;
    chk("R8 sec cleared", sec_flag, 0);

    // R4 invalid hit way
    clear_all();
    setup(730);
    tg[4*TW +: TW] = tag_of(4, 730, 1'b0);
    cw[4*CW +: CW] = enc(tg[4*TW +: TW]);
    drive(730, 4);
    chk("R4 invalid entry", hit_valid, 0);
    settle();

    // R10 checking disabled
    clear_all();
    ecc_en = 0;
    setup(740); cw[3*CW + 18] ^= 1'b1; cw[0*CW + 1] ^= 1'b1; cw[0*CW + 2] ^= 1'b1;
    etg = tg;
    etg[3*TW +: TW] = cw[3*CW +: TW];
    etg[0*TW +: TW] = cw[0*CW +: TW];
    drive(740, 3);
    chk("R10 raw pass-through", tag_out, etg);
    chk("R10 raw valid bit", hit_valid, 0);
    settle();
    chk("R10 no flags", {sec_flag, ded_flag}, 2'b00);
    chk("R10 log unchanged", log_idx, 710);
    ecc_en = 1;

    // R11 no probe
    clear_all();
    setup(750); cw[0] ^= 1'b1; cw[5*CW + 3] ^= 1'b1; cw[5*CW + 4] ^= 1'b1;
    code_in = cw; probe_idx = 11'd750;
    @(negedge clk); @(negedge clk);
    chk("R11 no probe no flags", {sec_flag, ded_flag}, 2'b00);
    chk("R11 no probe no log", log_idx, 710);

    // R9 interrupt enables
    sec_ie = 1; ded_ie = 1; #1;
    chk("R9 irq idle", irq, 0);
    setup(760); cw[2*CW + 5] ^= 1'b1; drive(760, 2); settle();
    sec_ie = 1; ded_ie = 0; #1;
    chk("R9 irq sec enabled", irq, 1);
    sec_ie = 0; #1;
    chk("R9 irq sec masked", irq, 0);
    @(negedge clk);
    setup(770); cw[2*CW + 5] ^= 1'b1; cw[2*CW + 6] ^= 1'b1; drive(770, 2); settle();
    ded_ie = 1; #1;
    chk("R9 irq ded enabled", irq, 1);
    ded_ie = 0; #1;
    chk("R9 irq ded masked", irq, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule